// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block is the code-fetch half of a 16-bit processor's bus interface. It keeps a 16-bit code segment value and two 16-bit offsets: a fetch offset that runs ahead of execution, and an execution offset that names the byte now at the head of the queue. A fetch address is formed by shifting the segment left by four bits and adding the fetch offset. The sum wraps modulo 2^20. Code bytes are requested one at a time on a request/ready port, and their replies come back on a valid/byte port. Each reply is written into a six-entry byte FIFO, and the execution side drains that FIFO one byte per cycle.

A redirect carries a new segment and offset. It empties the queue, reloads both offsets, and makes every reply still owed by the memory side stale, so that reply is thrown away when it arrives. On every cycle the block reports a two-bit queue status for the previous clock edge: idle, first opcode byte taken, later byte taken, or queue emptied. The consumer marks opcode-start bytes with a separate input.

The memory side must answer accepted requests in order, with at most one reply per cycle, and never in the cycle in which the request was accepted.

Top module: `pfq_fetch_unit`

## Requirements
- R1: One clock edge with `rst` high gives `q_level` = 0, `q_valid` = 0, `q_status` = 00, `ip_out` = 0000h, `cs_out` = FFFFh and `fetch_addr` = FFFF0h. After reset is released, bytes are fetched from FFFF:0000 upward.
- R2: `fetch_addr` equals (segment × 16 + fetch offset) mod 2^20. For example, 4321:1000 gives 44210h, FFFF:0010 gives 00000h and FFFF:FFFF gives 0FFEFh.
- R3: Each accepted request (`fetch_req` and `fetch_rdy` high at an edge) advances the fetch offset by one, modulo 2^16. The bytes reach the queue head in increasing offset order, starting from the latest redirect target.
- R4: The queue holds up to 6 bytes in first-in first-out order. `q_byte` is the oldest byte, and `q_valid` is high exactly when `q_level` is nonzero.
- R5: `fetch_req` is high exactly when `q_level` plus the number of outstanding requests is below 6 and fewer than 2 requests are outstanding. It is low while `q_level` is 6, and it rises in the cycle after a byte is taken from a full queue.
- R6: One cycle after `redir_valid` is high, `q_level` is 0, `cs_out` and `ip_out` hold the new segment and offset, `fetch_addr` points at the new target, and `q_status` is 10.
- R7: A reply to any request accepted before a redirect, or at the same edge as a redirect, is discarded and never reaches the queue.
- R8: `q_status` reports the action at the previous edge. A take with `take_first` high gives 01, a take with `take_first` low gives 11, and no take gives 00. A take while `q_valid` is low is ignored: the status is 00 and `ip_out` is unchanged.
- R9: When a redirect and a take occur at the same edge, the redirect wins. The status is 10, no byte is consumed, and `ip_out` becomes the new offset.
- R10: `ip_out` is the offset of the byte at the queue head. It rises by one (mod 2^16) for each accepted take and is not moved by prefetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Branch redirect strobe |
| redir_seg | input | 16 | New code segment value |
| redir_off | input | 16 | New code offset |
| fetch_req | output | 1 | Code byte request |
| fetch_addr | output | 20 | Physical address of the requested byte |
| fetch_rdy | input | 1 | Memory side accepts the request this cycle |
| resp_valid | input | 1 | A code byte is returned this cycle |
| resp_byte | input | 8 | Returned code byte |
| take | input | 1 | Execution side consumes the head byte |
| take_first | input | 1 | The consumed byte starts an opcode |
| q_valid | output | 1 | Queue holds at least one byte |
| q_byte | output | 8 | Byte at the queue head |
| q_level | output | 3 | Number of bytes held |
| q_status | output | 2 | Queue status for the previous edge |
| ip_out | output | 16 | Offset of the head byte (execution offset) |
| cs_out | output | 16 | Current code segment |

## Verification
A corrupted fetch offset or segment shows up within one or two cycles as a wrong `fetch_addr`. It becomes visible to the consumer as a wrong `q_byte` as soon as that byte reaches the head, because the bench memory returns an address-derived byte. A stale-drop counter that is off by one lets a byte from the old stream surface as the first byte after a redirect, or swallows the first good byte. Either fault is caught by the first take that follows. A level or credit counter that drifts appears as `fetch_req` staying high at six bytes held, or never rising again once a slot frees. A wrong execution offset is exposed by `ip_out` on the very next take.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int SEG_W     = 16;
    localparam int OFF_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = SEG_W + SEG_SHIFT;
    localparam int BYTE_W    = 8;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PA_W-1:0]   pa_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Per-cycle queue report; the code values are seen by the consumer.
    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    typedef struct packed {
        logic valid;
        seg_t seg;
        off_t off;
    } redir_t;

    // Segment scaled by 16 plus offset, truncated to the address width.
    function automatic pa_t phys_addr(input seg_t seg, input off_t off);
        pa_t base;
        base = {seg, {SEG_SHIFT{1'b0}}};
        return base + pa_t'(off);
    endfunction

endpackage

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  byte_t                      push_data,
    input  logic                       pop,
    output byte_t                      head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       not_empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [PTR_W-1:0]        wr_ptr, rd_ptr;
    logic [CNT_W-1:0]        cnt_q;
    logic [DEPTH*BYTE_W-1:0] flat;
    logic                    do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign do_push = push && !flush && (cnt_q != CNT_W'(DEPTH));
    assign do_pop  = pop && !flush && (cnt_q != '0);

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        byte_t data_q;
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PTR_W'(e))) begin
                data_q <= push_data;
            end
        end
        assign flat[e*BYTE_W +: BYTE_W] = data_q;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assign head      = flat[BYTE_W*int'(rd_ptr) +: BYTE_W];
    assign level     = cnt_q;
    assign not_empty = (cnt_q != '0);

endmodule

// File: rtl/pfq_fetch_credit.sv
module pfq_fetch_credit #(
    parameter int DEPTH      = 6,
    parameter int MAX_FLIGHT = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       accept,
    input  logic                       rsp_valid,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       req_ok,
    output logic                       rsp_keep
);

    localparam int FL_W  = $clog2(MAX_FLIGHT+1);
    localparam int SUM_W = $clog2(DEPTH+MAX_FLIGHT+1);

    logic [FL_W-1:0] flight_q, drop_q, flight_d;
    logic            rsp_eff, rsp_stale;

    // A reply counts only if something is owed; stale replies come first.
    assign rsp_eff   = rsp_valid && (flight_q != '0);
    assign rsp_stale = rsp_eff && (drop_q != '0);
    assign rsp_keep  = rsp_eff && (drop_q == '0);
    assign flight_d  = flight_q + FL_W'(accept) - FL_W'(rsp_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            flight_q <= '0;
            drop_q   <= '0;
        end else begin
            flight_q <= flight_d;
            if (flush) drop_q <= flight_d;
            else       drop_q <= drop_q - FL_W'(rsp_stale);
        end
    end

    // Every in-flight request reserves a queue slot.
    assign req_ok = (flight_q < FL_W'(MAX_FLIGHT)) &&
                    ((SUM_W'(level) + SUM_W'(flight_q)) < SUM_W'(DEPTH));

endmodule

// File: rtl/pfq_addr_track.sv
module pfq_addr_track
    import pfq_pkg::*;
#(
    parameter seg_t RESET_SEG = 16'hFFFF,
    parameter off_t RESET_OFF = 16'h0000
) (
    input  logic   clk,
    input  logic   rst,
    input  redir_t redir,
    input  logic   accept,
    input  logic   consume,
    output pa_t    fetch_addr,
    output seg_t   seg_out,
    output off_t   exec_off
);

    seg_t seg_q;
    off_t fetch_off_q, exec_off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q       <= RESET_SEG;
            fetch_off_q <= RESET_OFF;
            exec_off_q  <= RESET_OFF;
        end else if (redir.valid) begin
            seg_q       <= redir.seg;
            fetch_off_q <= redir.off;
            exec_off_q  <= redir.off;
        end else begin
            if (accept)  fetch_off_q <= fetch_off_q + off_t'(1);
            if (consume) exec_off_q  <= exec_off_q + off_t'(1);
        end
    end

    assign fetch_addr = phys_addr(seg_q, fetch_off_q);
    assign seg_out    = seg_q;
    assign exec_off   = exec_off_q;

endmodule

// File: rtl/pfq_status_gen.sv
module pfq_status_gen
    import pfq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   took,
    input  logic   took_first,
    output qstat_e status
);

    always_ff @(posedge clk) begin
        if (rst)        status <= QS_IDLE;
        else if (flush) status <= QS_FLUSH;
        else if (took)  status <= took_first ? QS_FIRST : QS_NEXT;
        else            status <= QS_IDLE;
    end

endmodule

// File: rtl/pfq_fetch_unit.sv
module pfq_fetch_unit
    import pfq_pkg::*;
#(
    parameter int   DEPTH      = 6,
    parameter int   MAX_FLIGHT = 2,
    parameter seg_t RESET_SEG  = 16'hFFFF,
    parameter off_t RESET_OFF  = 16'h0000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       redir_valid,
    input  logic [15:0]                redir_seg,
    input  logic [15:0]                redir_off,
    output logic                       fetch_req,
    output logic [19:0]                fetch_addr,
    input  logic                       fetch_rdy,
    input  logic                       resp_valid,
    input  logic [7:0]                 resp_byte,
    input  logic                       take,
    input  logic                       take_first,
    output logic                       q_valid,
    output logic [7:0]                 q_byte,
    output logic [$clog2(DEPTH+1)-1:0] q_level,
    output logic [1:0]                 q_status,
    output logic [15:0]                ip_out,
    output logic [15:0]                cs_out
);

    redir_t redir;
    logic   accept, take_eff, rsp_keep, push, req_ok;
    qstat_e status;

    assign redir    = {redir_valid, redir_seg, redir_off};
    assign accept   = req_ok && fetch_rdy;
    assign take_eff = take && q_valid && !redir_valid;
    assign push     = rsp_keep && !redir_valid;

    pfq_addr_track #(
        .RESET_SEG (RESET_SEG),
        .RESET_OFF (RESET_OFF)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .redir      (redir),
        .accept     (accept),
        .consume    (take_eff),
        .fetch_addr (fetch_addr),
        .seg_out    (cs_out),
        .exec_off   (ip_out)
    );

    pfq_fetch_credit #(
        .DEPTH      (DEPTH),
        .MAX_FLIGHT (MAX_FLIGHT)
    ) u_credit (
        .clk       (clk),
        .rst       (rst),
        .flush     (redir_valid),
        .accept    (accept),
        .rsp_valid (resp_valid),
        .level     (q_level),
        .req_ok    (req_ok),
        .rsp_keep  (rsp_keep)
    );

    pfq_byte_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (redir_valid),
        .push      (push),
        .push_data (resp_byte),
        .pop       (take_eff),
        .head      (q_byte),
        .level     (q_level),
        .not_empty (q_valid)
    );

    pfq_status_gen u_status (
        .clk        (clk),
        .rst        (rst),
        .flush      (redir_valid),
        .took       (take_eff),
        .took_first (take_first),
        .status     (status)
    );

    assign fetch_req = req_ok;
    assign q_status  = status;

endmodule

// File: rtl/pfq_fetch_unit_chk.sv
module pfq_fetch_unit_chk #(
    parameter int DEPTH = 6
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       redir_valid,
    input logic [15:0]                redir_seg,
    input logic [15:0]                redir_off,
    input logic                       fetch_req,
    input logic                       take,
    input logic                       take_first,
    input logic                       q_valid,
    input logic [$clog2(DEPTH+1)-1:0] q_level,
    input logic [1:0]                 q_status,
    input logic [15:0]                ip_out,
    input logic [15:0]                cs_out
);

    localparam int CNT_W = $clog2(DEPTH+1);

    p_level_bound_r4: assert property (@(posedge clk) disable iff (rst)
        q_level <= CNT_W'(DEPTH));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (q_level == CNT_W'(DEPTH)) |-> !fetch_req);

    p_flush_empties_r6: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (q_level == '0) && (q_status == 2'b10));

    p_flush_loads_r6: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (cs_out == $past(redir_seg)) && (ip_out == $past(redir_off)));

    p_seg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !redir_valid |=> $stable(cs_out));

    p_first_code_r8: assert property (@(posedge clk) disable iff (rst)
        (take && q_valid && take_first && !redir_valid) |=> (q_status == 2'b01));

    p_later_code_r8: assert property (@(posedge clk) disable iff (rst)
        (take && q_valid && !take_first && !redir_valid) |=> (q_status == 2'b11));

    p_empty_take_r8: assert property (@(posedge clk) disable iff (rst)
        (take && !q_valid && !redir_valid) |=> (q_status == 2'b00) && $stable(ip_out));

    p_ip_step_r10: assert property (@(posedge clk) disable iff (rst)
        (take && q_valid && !redir_valid) |=> (ip_out == $past(ip_out) + 16'd1));

    p_ip_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!take && !redir_valid) |=> $stable(ip_out));

endmodule

bind pfq_fetch_unit pfq_fetch_unit_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .redir_valid (redir_valid),
    .redir_seg   (redir_seg),
    .redir_off   (redir_off),
    .fetch_req   (fetch_req),
    .take        (take),
    .take_first  (take_first),
    .q_valid     (q_valid),
    .q_level     (q_level),
    .q_status    (q_status),
    .ip_out      (ip_out),
    .cs_out      (cs_out)
);

// File: tb/test_pfq_fetch_unit.sv
module test_pfq_fetch_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        redir_valid;
    logic [15:0] redir_seg, redir_off;
    logic        fetch_req;
    logic [19:0] fetch_addr;
    logic        fetch_rdy  = 1'b0;
    logic        resp_valid = 1'b0;
    logic [7:0]  resp_byte  = 8'h00;
    logic        take, take_first;
    logic        q_valid;
    logic [7:0]  q_byte;
    logic [2:0]  q_level;
    logic [1:0]  q_status;
    logic [15:0] ip_out, cs_out;

    int   checks = 0;
    int   fails  = 0;
    bit   rdy_en  = 1'b1;
    bit   resp_en = 1'b1;
    logic [19:0] mq [16];
    int   mq_cnt = 0;

    // Redirect targets {segment, offset, expected physical address}.
    localparam logic [51:0] VEC [6] = '{
        {16'h4321, 16'h1000, 20'h44210},
        {16'hF000, 16'hFFFE, 20'hFFFFE},
        {16'hFFFF, 16'h0010, 20'h00000},
        {16'h0000, 16'h0000, 20'h00000},
        {16'h1234, 16'h5678, 20'h179B8},
        {16'hFFFF, 16'hFFFF, 20'h0FFEF}
    };

    always #5 clk = ~clk;

    pfq_fetch_unit i_pfq_fetch_unit (
        .clk         (clk),
        .rst         (rst),
        .redir_valid (redir_valid),
        .redir_seg   (redir_seg),
        .redir_off   (redir_off),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_rdy   (fetch_rdy),
        .resp_valid  (resp_valid),
        .resp_byte   (resp_byte),
        .take        (take),
        .take_first  (take_first),
        .q_valid     (q_valid),
        .q_byte      (q_byte),
        .q_level     (q_level),
        .q_status    (q_status),
        .ip_out      (ip_out),
        .cs_out      (cs_out)
    );

    function automatic logic [19:0] b_phys(input logic [15:0] seg, input logic [15:0] off);
        logic [31:0] t;
        t = {16'h0, seg} * 32'd16 + {16'h0, off};
        return t[19:0];
    endfunction

    function automatic logic [7:0] b_mem(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // In-order memory model, at least one cycle of latency.
    always @(negedge clk) begin
        if (rst) begin
            mq_cnt     = 0;
            resp_valid = 1'b0;
            fetch_rdy  = 1'b0;
        end else begin
            if (resp_en && mq_cnt > 0) begin
                resp_valid = 1'b1;
                resp_byte  = b_mem(mq[0]);
                for (int k = 0; k < 15; k++) mq[k] = mq[k+1];
                mq_cnt--;
            end else begin
                resp_valid = 1'b0;
            end
            fetch_rdy = rdy_en;
            if (fetch_req && fetch_rdy && mq_cnt < 16) begin
                mq[mq_cnt] = fetch_addr;
                mq_cnt++;
            end
        end
    end

    task automatic wait_valid();
        int n = 0;
        while (!q_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (!q_valid) chk("R4 data never arrived", 32'd0, 32'd1);
    endtask

    task automatic consume(input logic [15:0] seg, input logic [15:0] off, input int n);
        for (int i = 0; i < n; i++) begin
            logic [15:0] o;
            o = off + 16'(i);
            wait_valid();
            chk("R3 byte order", q_byte, b_mem(b_phys(seg, o)));
            chk("R10 ip tracks head", ip_out, o);
            take       = 1'b1;
            take_first = (i % 3 == 0);
            @(negedge clk);
            take = 1'b0;
            chk("R8 take status", q_status, (i % 3 == 0) ? 32'd1 : 32'd3);
        end
    endtask

    task automatic redirect(input logic [15:0] seg, input logic [15:0] off);
        redir_valid = 1'b1;
        redir_seg   = seg;
        redir_off   = off;
        @(negedge clk);
        redir_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R4 act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; redir_valid = 1'b0; redir_seg = '0; redir_off = '0;
        take = 1'b0; take_first = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 level", q_level, 0);
        chk("R1 valid", q_valid, 0);
        chk("R1 status", q_status, 0);
        chk("R1 ip", ip_out, 32'h0000);
        chk("R1 cs", cs_out, 32'hFFFF);
        chk("R1 addr", fetch_addr, 32'hFFFF0);
        rst = 1'b0;

        // R1 stream from the reset vector
        consume(16'hFFFF, 16'h0000, 3);

        // R5 fill to capacity, then free one slot
        repeat (20) @(negedge clk);
        chk("R5 level full", q_level, 6);
        chk("R5 no request when full", fetch_req, 0);
        chk("R4 head kept", q_byte, b_mem(20'hFFFF3));
        chk("R10 ip unmoved by prefetch", ip_out, 32'h0003);
        take = 1'b1; take_first = 1'b1;
        @(negedge clk);
        take = 1'b0;
        chk("R5 level after take", q_level, 5);
        chk("R5 request after slot frees", fetch_req, 1);

        // R9 redirect and take together
        take = 1'b1; take_first = 1'b1;
        redirect(16'h0100, 16'h0020);
        take = 1'b0;
        chk("R9 status flush", q_status, 2);
        chk("R9 ip new offset", ip_out, 32'h0020);
        chk("R9 level empty", q_level, 0);
        chk("R9 cs new", cs_out, 32'h0100);
        chk("R2 addr after redirect", fetch_addr, 32'h01020);

        // R8 take on empty queue is ignored
        rdy_en = 1'b0;
        redirect(16'h0500, 16'h0000);
        repeat (4) @(negedge clk);
        chk("R8 level empty", q_level, 0);
        take = 1'b1; take_first = 1'b0;
        @(negedge clk);
        take = 1'b0;
        chk("R8 empty take status", q_status, 0);
        chk("R8 empty take ip", ip_out, 32'h0000);
        chk("R8 empty take level", q_level, 0);

        // R7 replies owed to the old stream are dropped
        resp_en = 1'b0;
        rdy_en  = 1'b1;
        redirect(16'h2000, 16'h0000);
        repeat (4) @(negedge clk);
        chk("R5 outstanding limit", fetch_req, 0);
        redirect(16'h3000, 16'h0040);
        resp_en = 1'b1;
        wait_valid();
        chk("R7 first byte from new stream", q_byte, b_mem(20'h30040));
        consume(16'h3000, 16'h0040, 3);

        // R2 R3 R6 R10 table of redirect targets
        foreach (VEC[v]) begin
            logic [15:0] s, o;
            logic [19:0] pa;
            {s, o, pa} = VEC[v];
            redirect(s, o);
            chk("R2 fetch address", fetch_addr, pa);
            chk("R2 address model", b_phys(s, o), pa);
            chk("R6 level cleared", q_level, 0);
            chk("R6 status flush", q_status, 2);
            chk("R6 cs loaded", cs_out, s);
            chk("R6 ip loaded", ip_out, o);
            consume(s, o, 8);
        end

        summary();
        $finish;
    end

endmodule